// File: doc/BRIEF.md
# Daylight Saving Hour Adjuster

This block works next to a real-time-clock calendar counter. On each once-per-second update it reads the current time and date. It decides whether the next hours value must come from a daylight-saving rule instead of the normal increment. In spring the clock skips the hour after 1:59:59 AM and goes straight to 3:00:00 AM. In autumn the clock goes back from 1:59:59 AM to 1:00:00 AM, so that hour is repeated once.

The decision about which day qualifies is made at midnight, on the update that shows 00:00:00. The result is held for the rest of that day. When the override is taken, the block raises a one-cycle `ovrValid` pulse together with the replacement hours byte. The calendar loads that byte and rolls minutes and seconds to zero as usual. Both byte encodings (BCD and binary) are handled, and so are both hour formats (12-hour and 24-hour).

Top module: `dst_adj`

## Requirements
- R1: On a day armed as the spring day, an update strobe showing 01:59:59 AM produces `ovrValid`=1 with `ovrHours`=3, encoded in the current data mode, in the cycle after the strobe.
- R2: On a day armed as the autumn day, the first update strobe showing 01:59:59 AM produces `ovrValid`=1 with `ovrHours`=1 in the cycle after the strobe.
- R3: On the autumn day, a second update at 01:59:59 AM produces no override, so the clock advances normally to 2:00:00.
- R4: The day is armed only on the midnight update (00:00:00 in 24-hour mode, 12:00:00 AM in 12-hour mode), and only if `dstEn` is 1 at that update. Setting `dstEn` later in the same day arms nothing.
- R5: No override is produced while `dstEn` is 0. A day that is already armed still fires once `dstEn` returns to 1.
- R6: The spring day is a Sunday (`dowIn`=1) in month 4 with a date from 1 to 7. The autumn day is a Sunday in month 10 with a date of 25 or later.
- R7: `dataMode`=1 means all bytes are binary. `dataMode`=0 means they are packed BCD, so month 10 is 8'h10, minute 59 is 8'h59 and date 25 is 8'h25.
- R8: When `hourFmt`=0 (12-hour), `hoursIn` bit 7 is the PM flag and only AM hours are adjusted. A PM 1:59:59 produces no override. When `hourFmt`=1 (24-hour), the full byte is the hour.
- R9: After reset, `ovrValid` is 0 and no day is armed.
- R10: `ovrValid` rises only in the cycle after an update strobe and lasts one cycle. Without a strobe, matching inputs produce nothing.
- R11: A Sunday outside the date windows (for example 8 April or 24 October), or a non-Sunday inside a window, produces no override at 01:59:59.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updStrobe | input | 1 | One-cycle pulse marking the per-second update |
| dstEn | input | 1 | Daylight-saving enable |
| dataMode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hourFmt | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag in bit 7 |
| monthIn | input | 8 | Current month |
| dateIn | input | 8 | Current day of month |
| dowIn | input | 8 | Current day of week, 1 = Sunday |
| hoursIn | input | 8 | Current hours byte |
| minutesIn | input | 8 | Current minutes |
| secondsIn | input | 8 | Current seconds |
| ovrValid | output | 1 | Override pulse: load `ovrHours` instead of incrementing |
| ovrHours | output | 8 | Replacement hours byte |

## Verification
The bench checks the date windows exactly at their edges: 7 against 8 April, and 25 against 24 October, in binary. A comparator that is off by one would fire on the wrong Sunday or miss the right one. It passes through 01:59:59 twice on the autumn day; a design without the done flag would loop back to 1:00 forever. It raises the enable only after midnight has passed, which exposes a design that reads the enable at the adjustment time instead of at midnight. In 12-hour mode it drives 12 AM as midnight and a PM 1:59:59, which catch a design that treats hour zero as midnight or ignores the PM flag.

// File: rtl/dst_adj_pkg.sv
`timescale 1ns/1ps
package dst_adj_pkg;

  // datapath -> control: decoded conditions for the current sample
  typedef struct packed {
    logic midnight;    // time reads 00:00:00 (or 12:00:00 AM)
    logic springDay;   // date matches the spring jump Sunday
    logic fallDay;     // date matches the autumn fallback Sunday
    logic adjustTime;  // time reads 01:59:59 AM
  } dayStatus_t;

  // control -> datapath: one-cycle strobes
  typedef struct packed {
    logic fireSpring;
    logic fireFall;
  } ctrlStrobe_t;

  // decode a byte from BCD or binary into a plain number
  function automatic logic [7:0] toBin(input logic [7:0] v, input logic binMode);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = 8'(v[7:4]) * 8'd10;
    ones = 8'(v[3:0]);
    return binMode ? v : (tens + ones);
  endfunction

  // encode a plain number (< 100) into BCD or binary
  function automatic logic [7:0] fromBin(input logic [7:0] v, input logic binMode);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 8'd10);
    ones = 4'(v % 8'd10);
    return binMode ? v : {tens, ones};
  endfunction

endpackage

// File: rtl/dst_adj_datapath.sv
`timescale 1ns/1ps
module dst_adj_datapath
  import dst_adj_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned SUNDAY_CODE   = 1,
  parameter int unsigned SPRING_MONTH  = 4,
  parameter int unsigned FALL_MONTH    = 10,
  parameter int unsigned SPRING_LAST   = 7,
  parameter int unsigned FALL_FIRST    = 25,
  parameter int unsigned ADJ_HOUR      = 1,
  parameter int unsigned SPRING_TARGET = 3,
  parameter bit          OUT_REG       = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataMode,
  input  logic              hourFmt,
  input  logic [DATA_W-1:0] monthIn,
  input  logic [DATA_W-1:0] dateIn,
  input  logic [DATA_W-1:0] dowIn,
  input  logic [DATA_W-1:0] hoursIn,
  input  logic [DATA_W-1:0] minutesIn,
  input  logic [DATA_W-1:0] secondsIn,
  input  ctrlStrobe_t       strobes,
  output dayStatus_t        status,
  output logic              ovrValid,
  output logic [DATA_W-1:0] ovrHours
);

  localparam logic [7:0] SundayL      = 8'(SUNDAY_CODE);
  localparam logic [7:0] SpringMonthL = 8'(SPRING_MONTH);
  localparam logic [7:0] FallMonthL   = 8'(FALL_MONTH);
  localparam logic [7:0] SpringLastL  = 8'(SPRING_LAST);
  localparam logic [7:0] FallFirstL   = 8'(FALL_FIRST);
  localparam logic [7:0] AdjHourL     = 8'(ADJ_HOUR);
  localparam logic [7:0] SpringTgtL   = 8'(SPRING_TARGET);
  localparam logic [7:0] FallTgtL     = 8'(ADJ_HOUR);
  localparam logic [7:0] LastMinSecL  = 8'd59;
  localparam logic [7:0] NoonHourL    = 8'd12;

  logic [7:0] monthBin, dateBin, minBin, secBin, hourBin;
  logic [7:0] hourRaw;
  logic       isPm;

  // 12-hour mode carries the PM flag in the top bit of the hours byte
  always_comb begin
    isPm    = ~hourFmt & hoursIn[7];
    hourRaw = hourFmt ? hoursIn : {1'b0, hoursIn[6:0]};
  end

  always_comb begin
    monthBin = toBin(monthIn, dataMode);
    dateBin  = toBin(dateIn, dataMode);
    minBin   = toBin(minutesIn, dataMode);
    secBin   = toBin(secondsIn, dataMode);
    hourBin  = toBin(hourRaw, dataMode);
  end

  logic atTopOfHour;
  logic midnightHour;
  logic isSunday;

  always_comb begin
    atTopOfHour  = (minBin == 8'd0) && (secBin == 8'd0);
    midnightHour = hourFmt ? (hourBin == 8'd0) : (!isPm && hourBin == NoonHourL);
    isSunday     = (dowIn == SundayL);

    status.midnight   = atTopOfHour && midnightHour;
    status.springDay  = isSunday && (monthBin == SpringMonthL) &&
                        (dateBin != 8'd0) && (dateBin <= SpringLastL);
    status.fallDay    = isSunday && (monthBin == FallMonthL) &&
                        (dateBin >= FallFirstL);
    status.adjustTime = !isPm && (hourBin == AdjHourL) &&
                        (minBin == LastMinSecL) && (secBin == LastMinSecL);
  end

  // replacement hour; AM so the PM flag stays clear in 12-hour mode
  logic              nextValid;
  logic [DATA_W-1:0] nextHours;

  always_comb begin
    nextValid = strobes.fireSpring | strobes.fireFall;
    if (strobes.fireSpring)
      nextHours = DATA_W'(fromBin(SpringTgtL, dataMode));
    else if (strobes.fireFall)
      nextHours = DATA_W'(fromBin(FallTgtL, dataMode));
    else
      nextHours = '0;
  end

  generate
    if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk) begin
        if (!rstN) begin
          ovrValid <= 1'b0;
          ovrHours <= '0;
        end else begin
          ovrValid <= nextValid;
          ovrHours <= nextHours;
        end
      end
    end else begin : g_comb_out
      assign ovrValid = nextValid;
      assign ovrHours = nextHours;
    end
  endgenerate

endmodule

// File: rtl/dst_adj_ctrl.sv
`timescale 1ns/1ps
module dst_adj_ctrl
  import dst_adj_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        updStrobe,
  input  logic        dstEn,
  input  dayStatus_t  status,
  output ctrlStrobe_t strobes
);

  logic springArmed;
  logic fallArmed;
  logic fallDone;
  logic dayCheck;
  logic adjSlot;

  always_comb begin
    dayCheck           = updStrobe && status.midnight;
    adjSlot            = updStrobe && dstEn && status.adjustTime;
    strobes.fireSpring = adjSlot && springArmed;
    strobes.fireFall   = adjSlot && fallArmed && !fallDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      springArmed <= 1'b0;
      fallArmed   <= 1'b0;
      fallDone    <= 1'b0;
    end else if (dayCheck) begin
      springArmed <= dstEn && status.springDay;
      fallArmed   <= dstEn && status.fallDay;
      fallDone    <= 1'b0;
    end else if (strobes.fireFall) begin
      fallDone    <= 1'b1;
    end
  end

endmodule

// File: rtl/dst_adj.sv
`timescale 1ns/1ps
module dst_adj
  import dst_adj_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SUNDAY_CODE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updStrobe,
  input  logic              dstEn,
  input  logic              dataMode,
  input  logic              hourFmt,
  input  logic [DATA_W-1:0] monthIn,
  input  logic [DATA_W-1:0] dateIn,
  input  logic [DATA_W-1:0] dowIn,
  input  logic [DATA_W-1:0] hoursIn,
  input  logic [DATA_W-1:0] minutesIn,
  input  logic [DATA_W-1:0] secondsIn,
  output logic              ovrValid,
  output logic [DATA_W-1:0] ovrHours
);

  dayStatus_t  status;
  ctrlStrobe_t strobes;

  dst_adj_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .updStrobe (updStrobe),
    .dstEn     (dstEn),
    .status    (status),
    .strobes   (strobes)
  );

  dst_adj_datapath #(
    .DATA_W      (DATA_W),
    .SUNDAY_CODE (SUNDAY_CODE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dataMode  (dataMode),
    .hourFmt   (hourFmt),
    .monthIn   (monthIn),
    .dateIn    (dateIn),
    .dowIn     (dowIn),
    .hoursIn   (hoursIn),
    .minutesIn (minutesIn),
    .secondsIn (secondsIn),
    .strobes   (strobes),
    .status    (status),
    .ovrValid  (ovrValid),
    .ovrHours  (ovrHours)
  );

endmodule

// File: rtl/dst_adj_chk.sv
`timescale 1ns/1ps
module dst_adj_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              updStrobe,
  input logic              dstEn,
  input logic              dataMode,
  input logic              hourFmt,
  input logic [DATA_W-1:0] hoursIn,
  input logic [DATA_W-1:0] minutesIn,
  input logic              ovrValid,
  input logic [DATA_W-1:0] ovrHours
);

  // R10: an override only follows an update strobe
  p_after_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    ovrValid |-> $past(updStrobe));

  // R5: an override never follows a sample taken with the enable low
  p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    ovrValid |-> $past(dstEn));

  // R1 / R2: the replacement is 3 or 1, the same in both byte codes
  p_target_value_r1: assert property (@(posedge clk) disable iff (!rstN)
    ovrValid |-> (ovrHours == DATA_W'(3) || ovrHours == DATA_W'(1)));

  // R8: in 12-hour mode only an AM sample can cause an override
  p_am_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovrValid && !$past(hourFmt)) |-> !$past(hoursIn[7]));

  // R7: the sampled minutes read 59 in the active byte code
  p_minute_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    ovrValid |-> ($past(dataMode) ? ($past(minutesIn) == DATA_W'(59))
                                  : ($past(minutesIn) == DATA_W'(8'h59))));

endmodule

bind dst_adj dst_adj_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .updStrobe (updStrobe),
  .dstEn     (dstEn),
  .dataMode  (dataMode),
  .hourFmt   (hourFmt),
  .hoursIn   (hoursIn),
  .minutesIn (minutesIn),
  .ovrValid  (ovrValid),
  .ovrHours  (ovrHours)
);

// File: tb/dst_adj_tb.sv
`timescale 1ns/1ps
module dst_adj_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       updStrobe = 1'b0;
  logic       dstEn = 1'b0;
  logic       dataMode = 1'b0;
  logic       hourFmt = 1'b1;
  logic [7:0] monthIn = '0, dateIn = '0, dowIn = '0;
  logic [7:0] hoursIn = '0, minutesIn = '0, secondsIn = '0;
  logic       ovrValid;
  logic [7:0] ovrHours;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dst_adj u_dut (
    .clk(clk), .rstN(rstN), .updStrobe(updStrobe), .dstEn(dstEn),
    .dataMode(dataMode), .hourFmt(hourFmt), .monthIn(monthIn),
    .dateIn(dateIn), .dowIn(dowIn), .hoursIn(hoursIn),
    .minutesIn(minutesIn), .secondsIn(secondsIn),
    .ovrValid(ovrValid), .ovrHours(ovrHours)
  );

  function automatic logic [7:0] enc(input int v);
    return dataMode ? 8'(v) : {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic report(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one sample: drive at negedge, strobe through an edge, sample after it
  task automatic tick(input int mo, input int da, input int dw, input int hr,
                      input bit pm, input int mi, input int se, input bit stb,
                      output logic v, output logic [7:0] h);
    @(negedge clk);
    monthIn = enc(mo); dateIn = enc(da); dowIn = 8'(dw);
    hoursIn = enc(hr) | (pm ? 8'h80 : 8'h00);
    minutesIn = enc(mi); secondsIn = enc(se);
    updStrobe = stb;
    @(posedge clk); #2;
    v = ovrValid; h = ovrHours;
    @(negedge clk);
    updStrobe = 1'b0;
  endtask

  task automatic midnight(input int mo, input int da, input int dw, input string req);
    logic v; logic [7:0] h;
    tick(mo, da, dw, hourFmt ? 0 : 12, 1'b0, 0, 0, 1'b1, v, h);
    report({req, " midnight no override"}, v, 0);
  endtask

  task automatic adjust(input int mo, input int da, input int dw, input bit pm,
                        input bit expV, input int expH, input string req);
    logic v; logic [7:0] h;
    tick(mo, da, dw, 1, pm, 59, 59, 1'b1, v, h);
    report({req, " valid"}, v, expV);
    if (expV) begin
      report({req, " hours"}, h, enc(expH));
      @(posedge clk); #2;
      report("R10 one-cycle pulse", ovrValid, 0);
    end
  endtask

  task automatic t_reset;
    report("R9 reset valid", ovrValid, 0);
    dstEn = 1'b1; hourFmt = 1'b1; dataMode = 1'b0;
    adjust(4, 5, 1, 1'b0, 1'b0, 0, "R9 nothing armed after reset");
  endtask

  task automatic t_spring_bcd24;
    logic v; logic [7:0] h;
    dataMode = 1'b0; hourFmt = 1'b1; dstEn = 1'b1;
    midnight(4, 7, 1, "R6");
    tick(4, 7, 1, 1, 1'b0, 59, 58, 1'b1, v, h);
    report("R10 01:59:58 no override", v, 0);
    tick(4, 7, 1, 1, 1'b0, 59, 59, 1'b0, v, h);
    report("R10 no strobe no override", v, 0);
    adjust(4, 7, 1, 1'b0, 1'b1, 3, "R1 R6 R7 spring BCD 24h date 7");
  endtask

  task automatic t_spring_bin12;
    dataMode = 1'b1; hourFmt = 1'b0; dstEn = 1'b1;
    midnight(4, 1, 1, "R8");
    adjust(4, 1, 1, 1'b1, 1'b0, 0, "R8 PM 1:59:59 ignored");
    adjust(4, 1, 1, 1'b0, 1'b1, 3, "R1 R7 R8 spring binary 12h AM");
  endtask

  task automatic t_fall_bcd24;
    dataMode = 1'b0; hourFmt = 1'b1; dstEn = 1'b1;
    midnight(10, 31, 1, "R2");
    adjust(10, 31, 1, 1'b0, 1'b1, 1, "R2 R7 fallback BCD first pass");
    adjust(10, 31, 1, 1'b0, 1'b0, 0, "R3 second pass advances normally");
  endtask

  task automatic t_fall_bin_edges;
    dataMode = 1'b1; hourFmt = 1'b1; dstEn = 1'b1;
    midnight(10, 25, 1, "R6");
    adjust(10, 25, 1, 1'b0, 1'b1, 1, "R6 R7 fallback binary date 25");
    midnight(10, 24, 1, "R11");
    adjust(10, 24, 1, 1'b0, 1'b0, 0, "R11 date 24 October");
    midnight(4, 8, 1, "R11");
    adjust(4, 8, 1, 1'b0, 1'b0, 0, "R11 date 8 April");
    midnight(4, 3, 2, "R11");
    adjust(4, 3, 2, 1'b0, 1'b0, 0, "R11 Monday in window");
  endtask

  task automatic t_enable;
    dataMode = 1'b0; hourFmt = 1'b1;
    dstEn = 1'b0;
    midnight(4, 5, 1, "R4");
    dstEn = 1'b1;
    adjust(4, 5, 1, 1'b0, 1'b0, 0, "R4 enable after midnight not armed");
    midnight(4, 5, 1, "R5");
    dstEn = 1'b0;
    adjust(4, 5, 1, 1'b0, 1'b0, 0, "R5 enable low blocks");
    dstEn = 1'b1;
    adjust(4, 5, 1, 1'b0, 1'b1, 3, "R5 armed day fires when enabled");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2;
    report("R9 valid during reset", ovrValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_spring_bcd24();
    t_spring_bin12();
    t_fall_bcd24();
    t_fall_bin_edges();
    t_enable();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule